// File: doc/BRIEF.md
# Bitmap-compressed trie transition unit

This block performs a single step of a multi-pattern string-matching automaton whose current state is stored as a bitmap-compressed node. A fetch engine hands it one node record and one 8-bit input symbol. The block answers with three things. The first is the address of the next node record. The second is a flag that says whether the input symbol was used up. The third is the match-list pointer that the caller should report. Records arrive through a valid/ready handshake, and results leave through one.

A 256-bit child bitmap marks which symbols have a success edge. The children of a node sit next to each other in memory. The child selected by a symbol is found by its rank: the number of set bitmap bits below the symbol position. To keep the counting short, the record carries seven 8-bit prefix counts, one for each 32-bit word boundary. Only the bits inside a single 32-bit word are counted at run time. When the bitmap bit is clear, the automaton follows its failure link and does not advance in the input.

A record whose type bit does not mark a bitmap node gives an error result in place of a transition. A parameter sets the pipeline depth: one or two register stages.

Top module: `bmtrie_step`

## Requirements
- R1: When bit `sym` of `nd_bitmap` is 1 and the record is a bitmap node, the result has `res_consumed`=1, `res_ofs`=0 and `res_next` = `nd_child_ptr` + rank × `REC_BYTES`.
- R2: When bit `sym` of `nd_bitmap` is 0 and the record is a bitmap node, the result has `res_consumed`=0, `res_next`=`nd_fail_ptr` and `res_ofs`=`nd_fail_ofs`.
- R3: The rank has two parts, added together. The first part is 0 when `sym`<32; otherwise it is the prefix count for word w = `sym`/32, which is taken from `nd_summ[8(w-1)+7 : 8(w-1)]`. The second part is the number of set bits among bitmap positions 32w to `sym`−1. The prefix counts are used exactly as supplied and are not checked against the bitmap.
- R4: `nd_kind`=0 marks a bitmap node. When `nd_kind`=1, the result has `res_kind_err`=1, `res_consumed`=0, `res_next`=0, `res_ofs`=0 and `res_report`=0.
- R5: `res_report` is 1 and `res_match_ptr` equals `nd_match_ptr` when three conditions all hold: `nd_entered_hit`=1 (the node was entered by a success edge), `nd_match_ptr` is non-zero, and the record is a bitmap node. In every other case `res_report`=0 and `res_match_ptr`=0.
- R6: While `res_ready` is held at 1, a record accepted at one rising edge shows up on `res_valid` exactly `PIPE_STAGES` rising edges later (2 by default).
- R7: While `res_valid`=1 and `res_ready`=0, every result output holds its value. Records are delivered in the order they were accepted, none is lost and none is delivered twice. `nd_ready` goes to 0 once every stage is full.
- R8: After reset, `res_valid`=0 and `nd_ready`=1.
- R9: The address sum is unsigned 32-bit arithmetic that wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nd_valid | input | 1 | Node record and symbol are valid |
| nd_ready | output | 1 | Block can accept a record |
| nd_kind | input | 1 | Node type bit, 0 = bitmap node |
| nd_fail_ofs | input | 3 | Offset into the failure target |
| nd_summ | input | 56 | Seven 8-bit prefix counts, count j at bits 8(j-1)+7:8(j-1) |
| nd_fail_ptr | input | 32 | Failure target address |
| nd_bitmap | input | 256 | Child bitmap, bit i = success edge on symbol i |
| nd_match_ptr | input | 32 | Match-list pointer of this node |
| nd_child_ptr | input | 32 | Address of the first child record |
| nd_entered_hit | input | 1 | This node was entered by a success edge |
| sym | input | 8 | Current input symbol |
| res_valid | output | 1 | Result is valid |
| res_ready | input | 1 | Downstream takes the result |
| res_next | output | 32 | Next node address |
| res_ofs | output | 3 | Offset into the next node |
| res_consumed | output | 1 | Input symbol was used up |
| res_report | output | 1 | Match list to be reported |
| res_match_ptr | output | 32 | Match-list pointer to report |
| res_kind_err | output | 1 | Record was not a bitmap node |

## Verification
Several internal faults show up at the ports with every result. A wrong word select, a wrong prefix-count pick or a wrong in-word mask makes `res_next` wrong by a multiple of the record size, starting from the first symbol past the affected boundary. A wrong hit decode swaps the child address for the failure address and flips `res_consumed` in the same result. A pipeline valid bit or hold enable that misbehaves surfaces as a result one cycle early or late, or as a result that changes or repeats while the output is stalled. A sweep over all 256 symbols under several bitmaps exposes every such fault within its first few hundred transactions.

// File: rtl/bmtrie_pkg.sv
package bmtrie_pkg;

  localparam int PTR_W  = 32;
  localparam int RANK_W = 9;
  localparam int OFS_W  = 3;

  typedef struct packed {
    logic              err;
    logic              hit;
    logic [RANK_W-1:0] rank;
    logic [PTR_W-1:0]  child;
    logic [PTR_W-1:0]  fail;
    logic [OFS_W-1:0]  ofs;
    logic              rep;
    logic [PTR_W-1:0]  rep_ptr;
  } mid_t;

  typedef struct packed {
    logic             err;
    logic             consumed;
    logic [PTR_W-1:0] next;
    logic [OFS_W-1:0] ofs;
    logic             rep;
    logic [PTR_W-1:0] rep_ptr;
  } res_t;

  // base + rank * rec, built from shifted copies of rank, no multiplier
  function automatic logic [PTR_W-1:0] scale_add(input logic [PTR_W-1:0]  base,
                                                 input logic [RANK_W-1:0] rank,
                                                 input int                rec);
    logic [PTR_W-1:0] acc;
    logic [PTR_W-1:0] r;
    acc = base;
    r   = PTR_W'(rank);
    for (int k = 0; k < 16; k++) begin
      if (((rec >> k) & 1) == 1) acc = acc + (r << k);
    end
    return acc;
  endfunction

  // ones in the bits of w strictly below position lim
  function automatic int low_ones32(input logic [31:0] w, input int lim);
    int c;
    c = 0;
    for (int k = 0; k < 32; k++) begin
      if (k < lim && w[k]) c = c + 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/bmt_rank.sv
module bmt_rank #(
  parameter int SYM_W  = 8,
  parameter int WORD_W = 32,
  parameter int SUM_W  = 8,
  parameter int RANK_W = 9,
  localparam int NSYM  = 1 << SYM_W,
  localparam int NWORD = NSYM / WORD_W,
  localparam int NSUM  = NWORD - 1,
  localparam int BW    = $clog2(WORD_W)
) (
  input  logic [NSYM-1:0]       bitmap,
  input  logic [NSUM*SUM_W-1:0] summ,
  input  logic [SYM_W-1:0]      sym,
  output logic                  hit,
  output logic [RANK_W-1:0]     rank
);
  import bmtrie_pkg::*;

  logic [SYM_W-BW-1:0] widx;
  logic [BW-1:0]       bidx;
  logic [WORD_W-1:0]   word;
  logic [SUM_W-1:0]    base;
  logic [RANK_W-1:0]   in_word;

  assign widx = sym[SYM_W-1:BW];
  assign bidx = sym[BW-1:0];
  assign word = bitmap[int'(widx)*WORD_W +: WORD_W];
  assign hit  = word[bidx];

  always_comb begin
    if (widx == '0) base = '0;
    else            base = summ[(int'(widx)-1)*SUM_W +: SUM_W];
  end

  always_comb begin
    in_word = '0;
    for (int k = 0; k < WORD_W; k++) begin
      if (k < int'(bidx) && word[k]) in_word = in_word + 1'b1;
    end
  end

  assign rank = RANK_W'(base) + in_word;

  // R3: the in-word part can never exceed the bit position within the word
  always_comb begin
    a_r3_word_bound: assert (int'(in_word) <= int'(bidx));
  end

endmodule

// File: rtl/bmt_slot.sv
module bmt_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  output logic         in_r,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  input  logic         out_r,
  output logic [W-1:0] out_d
);
  logic         full;
  logic [W-1:0] data;

  assign in_r  = !full || out_r;
  assign out_v = full;
  assign out_d = data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (in_v && in_r) begin
      full <= 1'b1;
      data <= in_d;
    end else if (out_r) begin
      full <= 1'b0;
    end
  end

  // R7: a stalled result is held unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_v && !out_r |=> out_v && $stable(out_d));

endmodule

// File: rtl/bmtrie_step.sv
module bmtrie_step #(
  parameter int PIPE_STAGES = 2,
  parameter int REC_BYTES   = 52,
  parameter int SYM_W       = 8,
  parameter int WORD_W      = 32,
  parameter int SUM_W       = 8,
  localparam int NSYM  = 1 << SYM_W,
  localparam int NWORD = NSYM / WORD_W,
  localparam int NSUM  = NWORD - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  nd_valid,
  output logic                  nd_ready,
  input  logic                  nd_kind,
  input  logic [2:0]            nd_fail_ofs,
  input  logic [NSUM*SUM_W-1:0] nd_summ,
  input  logic [31:0]           nd_fail_ptr,
  input  logic [NSYM-1:0]       nd_bitmap,
  input  logic [31:0]           nd_match_ptr,
  input  logic [31:0]           nd_child_ptr,
  input  logic                  nd_entered_hit,
  input  logic [SYM_W-1:0]      sym,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [31:0]           res_next,
  output logic [2:0]            res_ofs,
  output logic                  res_consumed,
  output logic                  res_report,
  output logic [31:0]           res_match_ptr,
  output logic                  res_kind_err
);
  import bmtrie_pkg::*;

  localparam logic KIND_BITMAP = 1'b0;

  logic              hit_w;
  logic [RANK_W-1:0] rank_w;
  mid_t              mid_in, mid_q;
  logic              mid_v, mid_r;
  res_t              res_in, res_q;

  bmt_rank #(.SYM_W(SYM_W), .WORD_W(WORD_W), .SUM_W(SUM_W), .RANK_W(RANK_W)) u_rank (
    .bitmap (nd_bitmap),
    .summ   (nd_summ),
    .sym    (sym),
    .hit    (hit_w),
    .rank   (rank_w)
  );

  always_comb begin
    mid_in.err     = (nd_kind != KIND_BITMAP);
    mid_in.hit     = hit_w;
    mid_in.rank    = rank_w;
    mid_in.child   = nd_child_ptr;
    mid_in.fail    = nd_fail_ptr;
    mid_in.ofs     = nd_fail_ofs;
    mid_in.rep     = nd_entered_hit && (nd_match_ptr != '0) && (nd_kind == KIND_BITMAP);
    mid_in.rep_ptr = nd_match_ptr;
  end

  generate
    if (PIPE_STAGES >= 2) begin : g_two
      bmt_slot #(.W($bits(mid_t))) u_mid (
        .clk (clk), .rst_n (rst_n),
        .in_v (nd_valid), .in_r (nd_ready), .in_d (mid_in),
        .out_v (mid_v), .out_r (mid_r), .out_d (mid_q)
      );
    end else begin : g_one
      assign mid_v    = nd_valid;
      assign mid_q    = mid_in;
      assign nd_ready = mid_r;
    end
  endgenerate

  always_comb begin
    res_in = '0;
    if (mid_q.err) begin
      res_in.err = 1'b1;
    end else if (mid_q.hit) begin
      res_in.consumed = 1'b1;
      res_in.next     = scale_add(mid_q.child, mid_q.rank, REC_BYTES);
    end else begin
      res_in.next = mid_q.fail;
      res_in.ofs  = mid_q.ofs;
    end
    if (mid_q.rep) begin
      res_in.rep     = 1'b1;
      res_in.rep_ptr = mid_q.rep_ptr;
    end
  end

  bmt_slot #(.W($bits(res_t))) u_out (
    .clk (clk), .rst_n (rst_n),
    .in_v (mid_v), .in_r (mid_r), .in_d (res_in),
    .out_v (res_valid), .out_r (res_ready), .out_d (res_q)
  );

  assign res_next      = res_q.next;
  assign res_ofs       = res_q.ofs;
  assign res_consumed  = res_q.consumed;
  assign res_report    = res_q.rep;
  assign res_match_ptr = res_q.rep_ptr;
  assign res_kind_err  = res_q.err;

  // R4: an error result carries no transition and no report
  a_r4_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind_err |-> !res_consumed && !res_report && res_next == '0);

  // R1: a consumed symbol always lands at offset zero
  a_r1_hit_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_consumed |-> res_ofs == '0 && !res_kind_err);

  // R5: a report never carries a null pointer
  a_r5_report_nonnull: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_report |-> res_match_ptr != '0);

  // R7: input stalls only while the output is stalled
  a_r7_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    !nd_ready |-> res_valid && !res_ready);

endmodule

// File: tb/sim_bmtrie_step.sv
module sim_bmtrie_step;
  localparam int PERIOD = 10;
  localparam int REC    = 52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nd_valid = 1'b0, nd_ready;
  logic nd_kind = 1'b0;
  logic [2:0] nd_fail_ofs = '0;
  logic [55:0] nd_summ = '0;
  logic [31:0] nd_fail_ptr = '0;
  logic [255:0] nd_bitmap = '0;
  logic [31:0] nd_match_ptr = '0;
  logic [31:0] nd_child_ptr = '0;
  logic nd_entered_hit = 1'b0;
  logic [7:0] sym = '0;
  logic res_valid, res_ready = 1'b1;
  logic [31:0] res_next, res_match_ptr;
  logic [2:0] res_ofs;
  logic res_consumed, res_report, res_kind_err;

  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  bmtrie_step u0 (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] make_summ(input logic [255:0] b);
    logic [55:0] s;
    int c;
    s = '0;
    c = 0;
    for (int i = 0; i < 224; i++) begin
      c += int'(b[i]);
      if (i % 32 == 31) s[(i/32)*8 +: 8] = 8'(c);
    end
    return s;
  endfunction

  function automatic int exp_rank(input logic [255:0] b, input logic [55:0] s, input int i);
    int w, c;
    w = i / 32;
    c = (w == 0) ? 0 : int'(s[(w-1)*8 +: 8]);
    for (int k = w*32; k < i; k++) c += int'(b[k]);
    return c;
  endfunction

  task automatic run_one(input int s, input string tag);
    int lat;
    bit hit;
    logic [31:0] en;
    logic [2:0] eo;
    bit ec, er, ee;
    logic [31:0] ep;
    @(negedge clk);
    sym = 8'(s);
    nd_valid = 1'b1;
    @(negedge clk);
    nd_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    hit = nd_bitmap[s];
    ee = nd_kind;
    if (ee) begin en = 0; eo = 0; ec = 0; end
    else if (hit) begin en = nd_child_ptr + 32'(exp_rank(nd_bitmap, nd_summ, s) * REC); eo = 0; ec = 1; end
    else begin en = nd_fail_ptr; eo = nd_fail_ofs; ec = 0; end
    er = nd_entered_hit && nd_match_ptr != 0 && !ee;
    ep = er ? nd_match_ptr : 0;
    check(lat == 2, "R6 latency", lat, 2);
    check(res_next == en && res_ofs == eo && res_consumed == ec && res_kind_err == ee,
          tag, {res_next, 4'(res_ofs), 3'(res_consumed), 1'(res_kind_err)},
          {en, 4'(eo), 3'(ec), 1'(ee)});
    check(res_report == er && res_match_ptr == ep, "R5 report", {res_match_ptr, 8'(res_report)},
          {ep, 8'(er)});
  endtask

  task automatic sweep(input logic [255:0] b, input string tag);
    nd_bitmap = b;
    nd_summ = make_summ(b);
    for (int s = 0; s < 256; s++) run_one(s, tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] lf;
    logic [31:0] x;
    repeat (3) @(negedge clk);
    check(res_valid == 0 && nd_ready == 0 || res_valid == 0, "R8 reset valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 0 && nd_ready == 1, "R8 reset state", {res_valid, nd_ready}, 1);

    nd_child_ptr = 32'h0001_0000;
    nd_fail_ptr = 32'h0000_4440;
    nd_fail_ofs = 3'd5;
    nd_match_ptr = 32'h0000_0bad;
    nd_entered_hit = 1'b1;
    sweep('0, "R2 miss");
    sweep('1, "R1 all-ones");
    sweep({64{4'h5}}, "R3 alternating");
    x = 32'hace1_2345;
    for (int i = 0; i < 8; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      lf[i*32 +: 32] = x;
    end
    nd_entered_hit = 1'b0;
    sweep(lf, "R1 R3 mixed");

    // R3: prefix counts used as supplied
    nd_bitmap = lf;
    nd_summ = make_summ(lf) ^ 56'h0305_0709_0b0d_11;
    for (int s = 30; s < 256; s += 37) run_one(s, "R3 given summary");

    // R5: null pointer suppresses report
    nd_entered_hit = 1'b1;
    nd_match_ptr = 32'h0;
    run_one(7, "R5 null match");
    nd_match_ptr = 32'h0000_0bad;

    // R9: wrap
    nd_bitmap = '1;
    nd_summ = make_summ('1);
    nd_child_ptr = 32'hFFFF_FF00;
    run_one(200, "R9 wrap");
    run_one(255, "R9 wrap top");

    // R4: non-bitmap record
    nd_kind = 1'b1;
    run_one(3, "R4 kind error");
    nd_bitmap = '0;
    run_one(90, "R4 kind error miss");
    nd_kind = 1'b0;

    // R7: back-pressure, order and hold
    nd_bitmap = '1;
    nd_summ = make_summ('1);
    nd_child_ptr = 32'h0000_1000;
    @(negedge clk);
    res_ready = 1'b0;
    sym = 8'd1;
    nd_valid = 1'b1;
    @(negedge clk);
    sym = 8'd2;
    @(negedge clk);
    nd_valid = 1'b0;
    check(nd_ready == 0, "R7 ready low when full", nd_ready, 0);
    for (int i = 0; i < 3; i++) begin
      check(res_valid == 1 && res_next == 32'h1000 + 52, "R7 hold first", res_next, 32'h1000 + 52);
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    check(res_valid == 1 && res_next == 32'h1000 + 104, "R7 second in order", res_next, 32'h1000 + 104);
    @(negedge clk);
    check(res_valid == 0, "R7 no duplicate", res_valid, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule